// File: doc/BRIEF.md
# Dual-Mode Down-Counting Timer

This block is a general-purpose timer that software controls through a simple register write and read port. One counter pair works either as a single 32-bit down-counter or as two independent 16-bit down-counters, called A and B. In the paired 16-bit configuration each half picks its own behaviour: it can stop after one pass, reload and repeat, or produce a pulse-width-modulated waveform. Each half also has an 8-bit prescaler that stretches its count range.

Every timer signals its expiry with a single-cycle timeout pulse. A per-timer enable decides whether that pulse is also driven out as a trigger. In PWM mode the prescale register and the prescale match register become the upper byte of a 24-bit count and a 24-bit compare. A per-half polarity bit can invert the PWM output. A debug-halt input freezes any timer whose stall bit is set.

A write to the configuration register always leaves both timers stopped. A write to a load register while its timer is running restarts the count from the new value.

Top module: `gp_dual_timer`

## Requirements
- R1: After reset every register reads back zero, both timers are stopped, and timeout_a, timeout_b, trig_a, trig_b, pwm_a and pwm_b are all low.
- R2: The register offsets are 0 control, 1 configuration, 2 load A (32 bits), 3 load B, 4 match A, 5 match B, 6 prescale A, 7 prescale B, 8 prescale match A, 9 prescale match B, 10 count A and 11 count B. The two count registers are read-only. Control bits: 0 enable A, 1 enable B, 2 stall A, 3 stall B, 4 invert A, 5 invert B, 6 trigger A, 7 trigger B. Configuration bits [1:0] select the global mode: 0 = split 16-bit, 1 = 32-bit one-shot, 2 = 32-bit periodic, 3 = hold. Bits [3:2] select the mode of half A and bits [5:4] the mode of half B: 0 = one-shot, 1 = periodic, 2 = PWM, 3 = hold. A written value reads back on the next cycle.
- R3: Any write to the configuration register clears both enable bits.
- R4: In split mode a periodic half loaded with L and prescale P produces timeout pulses exactly (L+1)*(P+1) cycles apart. The first pulse is seen 1+(L+1)*(P+1) cycles after the edge that writes the enable bit.
- R5: A one-shot half produces a single timeout pulse. In the same cycle its enable bit clears, and its count stays at zero afterwards.
- R6: A write to the load register of an enabled timer restarts the count from the new value. With prescale 0 the next timeout is seen L+2 cycles after the write edge.
- R7: While dbg_halt is high, a timer whose stall bit is set holds its count. A timer whose stall bit is clear keeps counting.
- R8: The trigger output of a timer pulses together with its timeout only when that timer's trigger bit is set. Otherwise it stays low.
- R9: In PWM mode, before any inversion, the output is high while the count is above the match value. The period is load+1 cycles, so a window of one period holds load-match high cycles. Setting the invert bit swaps the output levels.
- R10: In PWM mode the prescale and load registers together form a 24-bit start value. The prescale match and match registers together form a 24-bit compare value.
- R11: In the 32-bit modes timer A counts the full 32-bit load value and ignores its prescaler. Half B does not count and never pulses timeout_b.
- R12: Whenever half A is not in PWM mode, pwm_a equals its invert bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write offset |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read offset |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| dbg_halt | input | 1 | Debug halt request |
| timeout_a | output | 1 | Timeout pulse of timer A |
| timeout_b | output | 1 | Timeout pulse of timer B |
| trig_a | output | 1 | Gated trigger pulse of timer A |
| trig_b | output | 1 | Gated trigger pulse of timer B |
| pwm_a | output | 1 | PWM output of half A |
| pwm_b | output | 1 | PWM output of half B |

## Verification
A register write is visible on the read port one cycle after its edge. An enable write loads the counter on the next edge. The bench therefore counts falling edges from the write edge and expects the first timeout at 1+(L+1)*(P+1), a restart by a load write at L+2, and the 32-bit one-shot at load+2. PWM levels depend directly on the registered count, so the bench samples them at falling edges: either at a known number of edges after the enable or across whole-period windows, where the high count does not depend on phase. Stall and count readback are compared between reads taken a known number of falling edges apart.

// File: rtl/gpt_pkg.sv
package gpt_pkg;

    localparam int unsigned ADDR_W = 4;

    typedef enum logic [1:0] {
        GM_SPLIT = 2'd0,
        GM_ONE32 = 2'd1,
        GM_PER32 = 2'd2,
        GM_HOLD  = 2'd3
    } glob_mode_e;

    typedef enum logic [1:0] {
        HM_ONESHOT  = 2'd0,
        HM_PERIODIC = 2'd1,
        HM_PWM      = 2'd2,
        HM_HOLD     = 2'd3
    } half_mode_e;

    typedef struct packed {
        logic trig_b;
        logic trig_a;
        logic inv_b;
        logic inv_a;
        logic stall_b;
        logic stall_a;
        logic en_b;
        logic en_a;
    } ctrl_t;

    typedef struct packed {
        half_mode_e mode_b;
        half_mode_e mode_a;
        glob_mode_e glob;
    } cfg_t;

    localparam logic [ADDR_W-1:0] OFS_CTRL   = 4'd0;
    localparam logic [ADDR_W-1:0] OFS_CFG    = 4'd1;
    localparam logic [ADDR_W-1:0] OFS_LOAD_A = 4'd2;
    localparam logic [ADDR_W-1:0] OFS_LOAD_B = 4'd3;
    localparam logic [ADDR_W-1:0] OFS_MAT_A  = 4'd4;
    localparam logic [ADDR_W-1:0] OFS_MAT_B  = 4'd5;
    localparam logic [ADDR_W-1:0] OFS_PRE_A  = 4'd6;
    localparam logic [ADDR_W-1:0] OFS_PRE_B  = 4'd7;
    localparam logic [ADDR_W-1:0] OFS_PMAT_A = 4'd8;
    localparam logic [ADDR_W-1:0] OFS_PMAT_B = 4'd9;
    localparam logic [ADDR_W-1:0] OFS_CNT_A  = 4'd10;
    localparam logic [ADDR_W-1:0] OFS_CNT_B  = 4'd11;

    function automatic logic is_wide(glob_mode_e g);
        return (g == GM_ONE32) || (g == GM_PER32);
    endfunction

    function automatic half_mode_e mode_for_a(cfg_t c);
        case (c.glob)
            GM_SPLIT: return c.mode_a;
            GM_ONE32: return HM_ONESHOT;
            GM_PER32: return HM_PERIODIC;
            default:  return HM_HOLD;
        endcase
    endfunction

    function automatic half_mode_e mode_for_b(cfg_t c);
        return (c.glob == GM_SPLIT) ? c.mode_b : HM_HOLD;
    endfunction

endpackage

// File: rtl/gpt_regs.sv
module gpt_regs
    import gpt_pkg::*;
#(
    parameter int unsigned HALF_W = 16,
    parameter int unsigned PRE_W  = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [2*HALF_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]     rd_addr,
    output logic [2*HALF_W-1:0]   rd_data,
    input  logic                  stop_a,
    input  logic                  stop_b,
    input  logic [2*HALF_W-1:0]   cnt_a,
    input  logic [HALF_W-1:0]     cnt_b,
    output ctrl_t                 ctrl_o,
    output cfg_t                  cfg_o,
    output logic [2*HALF_W-1:0]   load_a_o,
    output logic [HALF_W-1:0]     load_b_o,
    output logic [HALF_W-1:0]     mat_a_o,
    output logic [HALF_W-1:0]     mat_b_o,
    output logic [PRE_W-1:0]      pre_a_o,
    output logic [PRE_W-1:0]      pre_b_o,
    output logic [PRE_W-1:0]      pmat_a_o,
    output logic [PRE_W-1:0]      pmat_b_o,
    output logic                  start_a,
    output logic                  start_b
);
    localparam int unsigned FULL_W = 2 * HALF_W;
    localparam int unsigned CTRL_W = $bits(ctrl_t);
    localparam int unsigned CFG_W  = $bits(cfg_t);

    ctrl_t ctrl_q, ctrl_wr;
    cfg_t  cfg_q;
    logic  start_a_d, start_b_d;

    assign ctrl_wr = ctrl_t'(wr_data[CTRL_W-1:0]);

    // Restart on an enable edge, or on a load write while already running.
    always_comb begin
        start_a_d = wr_en && (((wr_addr == OFS_CTRL) && ctrl_wr.en_a && !ctrl_q.en_a) ||
                              ((wr_addr == OFS_LOAD_A) && ctrl_q.en_a));
        start_b_d = wr_en && (((wr_addr == OFS_CTRL) && ctrl_wr.en_b && !ctrl_q.en_b) ||
                              ((wr_addr == OFS_LOAD_B) && ctrl_q.en_b));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            cfg_q    <= '0;
            load_a_o <= '0;
            load_b_o <= '0;
            mat_a_o  <= '0;
            mat_b_o  <= '0;
            pre_a_o  <= '0;
            pre_b_o  <= '0;
            pmat_a_o <= '0;
            pmat_b_o <= '0;
            start_a  <= 1'b0;
            start_b  <= 1'b0;
        end else begin
            start_a <= start_a_d;
            start_b <= start_b_d;
            if (stop_a) ctrl_q.en_a <= 1'b0;
            if (stop_b) ctrl_q.en_b <= 1'b0;
            if (wr_en) begin
                case (wr_addr)
                    OFS_CTRL:   ctrl_q <= ctrl_wr;
                    OFS_CFG: begin
                        cfg_q       <= cfg_t'(wr_data[CFG_W-1:0]);
                        ctrl_q.en_a <= 1'b0;
                        ctrl_q.en_b <= 1'b0;
                    end
                    OFS_LOAD_A: load_a_o <= wr_data;
                    OFS_LOAD_B: load_b_o <= wr_data[HALF_W-1:0];
                    OFS_MAT_A:  mat_a_o  <= wr_data[HALF_W-1:0];
                    OFS_MAT_B:  mat_b_o  <= wr_data[HALF_W-1:0];
                    OFS_PRE_A:  pre_a_o  <= wr_data[PRE_W-1:0];
                    OFS_PRE_B:  pre_b_o  <= wr_data[PRE_W-1:0];
                    OFS_PMAT_A: pmat_a_o <= wr_data[PRE_W-1:0];
                    OFS_PMAT_B: pmat_b_o <= wr_data[PRE_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (rd_addr)
            OFS_CTRL:   rd_data = FULL_W'(ctrl_q);
            OFS_CFG:    rd_data = FULL_W'(cfg_q);
            OFS_LOAD_A: rd_data = load_a_o;
            OFS_LOAD_B: rd_data = FULL_W'(load_b_o);
            OFS_MAT_A:  rd_data = FULL_W'(mat_a_o);
            OFS_MAT_B:  rd_data = FULL_W'(mat_b_o);
            OFS_PRE_A:  rd_data = FULL_W'(pre_a_o);
            OFS_PRE_B:  rd_data = FULL_W'(pre_b_o);
            OFS_PMAT_A: rd_data = FULL_W'(pmat_a_o);
            OFS_PMAT_B: rd_data = FULL_W'(pmat_b_o);
            OFS_CNT_A:  rd_data = cnt_a;
            OFS_CNT_B:  rd_data = FULL_W'(cnt_b);
            default:    rd_data = '0;
        endcase
    end

    assign ctrl_o = ctrl_q;
    assign cfg_o  = cfg_q;

endmodule

// File: rtl/gpt_half.sv
module gpt_half
    import gpt_pkg::*;
#(
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned HALF_W = 16,
    parameter int unsigned PRE_W  = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic               start,
    input  half_mode_e         mode,
    input  logic               wide,
    input  logic [CNT_W-1:0]   load_val,
    input  logic [PRE_W-1:0]   pre_val,
    input  logic [HALF_W-1:0]  mat_val,
    input  logic [PRE_W-1:0]   pmat_val,
    output logic [CNT_W-1:0]   cnt_o,
    output logic               timeout_o,
    output logic               stop_o,
    output logic               pwm_raw_o
);
    localparam int unsigned CMP_W = PRE_W + HALF_W;

    logic [CNT_W-1:0] cnt_q, eff_load;
    logic [PRE_W-1:0] ps_q;
    logic [CMP_W-1:0] comp, comp_dec;
    logic             to_q, pwm_mode, tick, at_zero, active;

    always_comb begin
        eff_load = wide ? load_val : CNT_W'(load_val[HALF_W-1:0]);
        comp     = {ps_q, cnt_q[HALF_W-1:0]};
        comp_dec = comp - 1'b1;
        pwm_mode = (mode == HM_PWM) && !wide;
        active   = run && (mode != HM_HOLD);
        // Prescaler only divides the plain 16-bit count modes.
        tick     = active && (wide || pwm_mode || (ps_q == '0));
        at_zero  = pwm_mode ? (comp == '0) : (cnt_q == '0);
    end

    assign stop_o    = tick && at_zero && (mode == HM_ONESHOT) && !start;
    assign pwm_raw_o = pwm_mode && (comp > {pmat_val, mat_val});
    assign cnt_o     = cnt_q;
    assign timeout_o = to_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            ps_q  <= '0;
            to_q  <= 1'b0;
        end else begin
            to_q <= 1'b0;
            if (start) begin
                cnt_q <= eff_load;
                ps_q  <= pre_val;
            end else if (active) begin
                if (pwm_mode) begin
                    if (at_zero) begin
                        to_q  <= 1'b1;
                        cnt_q <= eff_load;
                        ps_q  <= pre_val;
                    end else begin
                        ps_q  <= comp_dec[CMP_W-1:HALF_W];
                        cnt_q <= CNT_W'(comp_dec[HALF_W-1:0]);
                    end
                end else if (!tick) begin
                    ps_q <= ps_q - 1'b1;
                end else begin
                    if (!wide) ps_q <= pre_val;
                    if (at_zero) begin
                        to_q <= 1'b1;
                        if (mode == HM_PERIODIC) cnt_q <= eff_load;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/gp_dual_timer.sv
module gp_dual_timer
    import gpt_pkg::*;
#(
    parameter int unsigned HALF_W = 16,
    parameter int unsigned PRE_W  = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [3:0]           wr_addr,
    input  logic [2*HALF_W-1:0]  wr_data,
    input  logic [3:0]           rd_addr,
    output logic [2*HALF_W-1:0]  rd_data,
    input  logic                 dbg_halt,
    output logic                 timeout_a,
    output logic                 timeout_b,
    output logic                 trig_a,
    output logic                 trig_b,
    output logic                 pwm_a,
    output logic                 pwm_b
);
    localparam int unsigned FULL_W = 2 * HALF_W;

    ctrl_t               ctrl_q;
    cfg_t                cfg_q;
    logic [FULL_W-1:0]   load_a, cnt_a;
    logic [HALF_W-1:0]   load_b, mat_a, mat_b, cnt_b;
    logic [PRE_W-1:0]    pre_a, pre_b, pmat_a, pmat_b;
    logic                start_a, start_b, stop_a, stop_b;
    logic                run_a, run_b, wide, raw_a, raw_b;
    half_mode_e          mode_a, mode_b;

    assign wide   = is_wide(cfg_q.glob);
    assign mode_a = mode_for_a(cfg_q);
    assign mode_b = mode_for_b(cfg_q);
    assign run_a  = ctrl_q.en_a && !(ctrl_q.stall_a && dbg_halt);
    assign run_b  = ctrl_q.en_b && !(ctrl_q.stall_b && dbg_halt) && !wide;

    gpt_regs #(.HALF_W(HALF_W), .PRE_W(PRE_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .stop_a(stop_a), .stop_b(stop_b),
        .cnt_a(cnt_a), .cnt_b(cnt_b), .ctrl_o(ctrl_q), .cfg_o(cfg_q),
        .load_a_o(load_a), .load_b_o(load_b), .mat_a_o(mat_a), .mat_b_o(mat_b),
        .pre_a_o(pre_a), .pre_b_o(pre_b), .pmat_a_o(pmat_a), .pmat_b_o(pmat_b),
        .start_a(start_a), .start_b(start_b)
    );

    gpt_half #(.CNT_W(FULL_W), .HALF_W(HALF_W), .PRE_W(PRE_W)) u_half_a (
        .clk(clk), .rst(rst), .run(run_a), .start(start_a), .mode(mode_a), .wide(wide),
        .load_val(load_a), .pre_val(pre_a), .mat_val(mat_a), .pmat_val(pmat_a),
        .cnt_o(cnt_a), .timeout_o(timeout_a), .stop_o(stop_a), .pwm_raw_o(raw_a)
    );

    gpt_half #(.CNT_W(HALF_W), .HALF_W(HALF_W), .PRE_W(PRE_W)) u_half_b (
        .clk(clk), .rst(rst), .run(run_b), .start(start_b), .mode(mode_b), .wide(1'b0),
        .load_val(load_b), .pre_val(pre_b), .mat_val(mat_b), .pmat_val(pmat_b),
        .cnt_o(cnt_b), .timeout_o(timeout_b), .stop_o(stop_b), .pwm_raw_o(raw_b)
    );

    assign trig_a = timeout_a && ctrl_q.trig_a;
    assign trig_b = timeout_b && ctrl_q.trig_b;
    assign pwm_a  = raw_a ^ ctrl_q.inv_a;
    assign pwm_b  = raw_b ^ ctrl_q.inv_b;

endmodule

// File: rtl/gpt_checker.sv
module gpt_checker
    import gpt_pkg::*;
#(
    parameter int unsigned FULL_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [3:0]        wr_addr,
    input logic              dbg_halt,
    input ctrl_t             ctrl,
    input cfg_t              cfg,
    input logic              start_a,
    input logic              stop_a,
    input logic [FULL_W-1:0] cnt_a,
    input logic              timeout_b,
    input logic              pwm_a
);
    logic wide_now, a_is_pwm;
    assign wide_now = is_wide(cfg.glob);
    assign a_is_pwm = (cfg.glob == GM_SPLIT) && (cfg.mode_a == HM_PWM);

    p_cfg_stops_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == OFS_CFG) |=> (!ctrl.en_a && !ctrl.en_b));

    p_oneshot_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (stop_a && !(wr_en && wr_addr == OFS_CTRL)) |=> !ctrl.en_a);

    p_stall_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (ctrl.stall_a && dbg_halt && !start_a) |=> $stable(cnt_a));

    p_b_quiet_wide_r11: assert property (@(posedge clk) disable iff (rst)
        (wide_now && $past(wide_now)) |-> !timeout_b);

    p_pwm_idle_r12: assert property (@(posedge clk) disable iff (rst)
        !a_is_pwm |-> (pwm_a == ctrl.inv_a));

endmodule

bind gp_dual_timer gpt_checker #(.FULL_W(2*HALF_W)) i_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .dbg_halt(dbg_halt),
    .ctrl(ctrl_q), .cfg(cfg_q), .start_a(start_a), .stop_a(stop_a), .cnt_a(cnt_a),
    .timeout_b(timeout_b), .pwm_a(pwm_a)
);

// File: tb/test_gp_dual_timer.sv
module test_gp_dual_timer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        dbg_halt = 1'b0;
    logic        timeout_a, timeout_b, trig_a, trig_b, pwm_a, pwm_b;

    int checks = 0;
    int errors = 0;
    int tb_pulses = 0;
    int ta_pulses = 0;
    logic last_trig = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    gp_dual_timer i_gp_dual_timer (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .dbg_halt(dbg_halt),
        .timeout_a(timeout_a), .timeout_b(timeout_b), .trig_a(trig_a), .trig_b(trig_b),
        .pwm_a(pwm_a), .pwm_b(pwm_b)
    );

    always @(negedge clk) begin
        if (timeout_b) tb_pulses++;
        if (timeout_a) ta_pulses++;
    end

    function automatic int exp_period(int l, int p);
        return (l + 1) * (p + 1);
    endfunction

    function automatic int exp_high(int l, int m);
        return l - m;
    endfunction

    task automatic chk(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic wait_ta(int start, output int n);
        n = start;
        forever begin
            @(negedge clk);
            n++;
            if (timeout_a) begin
                last_trig = trig_a;
                break;
            end
            if (n > 150000) break;
        end
    endtask

    task automatic count_high(int win, output int h);
        h = 0;
        repeat (win) begin
            @(negedge clk);
            if (pwm_a) h++;
        end
    endtask

    task automatic summary;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] v, v1, v2;
        int n, h, l, p, m;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        for (int a = 0; a < 12; a++) begin
            rd(4'(a), v);
            chk("R1 reset reg", v, 0);
        end
        chk("R1 outputs", {timeout_a, timeout_b, trig_a, trig_b, pwm_a, pwm_b}, 0);

        // R2: register readback
        wr(4'd2, 32'hDEADBEEF); rd(4'd2, v); chk("R2 load A", v, 32'hDEADBEEF);
        wr(4'd3, 32'h1234BEEF); rd(4'd3, v); chk("R2 load B", v, 32'hBEEF);
        wr(4'd4, 32'h1234);     rd(4'd4, v); chk("R2 match A", v, 32'h1234);
        wr(4'd6, 32'h5A);       rd(4'd6, v); chk("R2 prescale A", v, 32'h5A);
        wr(4'd9, 32'hC3);       rd(4'd9, v); chk("R2 pmatch B", v, 32'hC3);
        wr(4'd1, 32'h3F);       rd(4'd1, v); chk("R2 cfg", v, 32'h3F);
        wr(4'd10, 32'h55);      rd(4'd10, v); chk("R2 count A read-only", v, 0);
        wr(4'd1, 32'h0);

        // R4 / R8: split periodic with random load and prescale
        for (int i = 0; i < 5; i++) begin
            l = int'($urandom % 20);
            p = int'($urandom % 4);
            wr(4'd1, 32'h04);
            wr(4'd2, 32'(l));
            wr(4'd6, 32'(p));
            wr(4'd0, (i == 0) ? 32'h41 : 32'h01);
            wait_ta(0, n);
            chk("R4 first timeout", n, 1 + exp_period(l, p));
            chk("R8 trigger gating", last_trig, (i == 0) ? 1 : 0);
            wait_ta(0, n);
            chk("R4 period", n, exp_period(l, p));
            wr(4'd1, 32'h04);
            rd(4'd0, v);
            chk("R3 cfg write stops", v[1:0], 0);
        end

        // R5: split one-shot
        wr(4'd1, 32'h00);
        wr(4'd2, 32'd7);
        wr(4'd6, 32'd1);
        wr(4'd0, 32'h01);
        wait_ta(0, n);
        chk("R5 one-shot timeout", n, 1 + exp_period(7, 1));
        rd(4'd0, v); chk("R5 enable cleared", v[0], 0);
        rd(4'd10, v); chk("R5 count zero", v, 0);
        ta_pulses = 0;
        repeat (40) @(negedge clk);
        chk("R5 single pulse", ta_pulses, 0);

        // R6: load while running
        wr(4'd1, 32'h04);
        wr(4'd2, 32'd100);
        wr(4'd6, 32'd0);
        wr(4'd0, 32'h01);
        wr(4'd2, 32'd3);
        wait_ta(0, n);
        chk("R6 reload on write", n, 3 + 2);
        wr(4'd1, 32'h00);

        // R7: stall with debug halt, half B
        dbg_halt = 1'b1;
        wr(4'd1, 32'h10);
        wr(4'd3, 32'd200);
        wr(4'd0, 32'h0A);
        repeat (3) @(negedge clk);
        rd(4'd11, v1); chk("R7 loaded", v1, 200);
        repeat (5) @(negedge clk);
        rd(4'd11, v2); chk("R7 frozen", v2, v1);
        dbg_halt = 1'b0;
        repeat (5) @(negedge clk);
        rd(4'd11, v2); chk("R7 resumes", v2, v1 - 5);
        dbg_halt = 1'b1;
        wr(4'd0, 32'h02);
        rd(4'd11, v1);
        repeat (4) @(negedge clk);
        rd(4'd11, v2); chk("R7 no stall bit", v2, v1 - 4);
        dbg_halt = 1'b0;
        wr(4'd1, 32'h00);

        // R11: 32-bit one-shot, prescale ignored, B held
        wr(4'd1, 32'h11);
        wr(4'd2, 32'h0001_0002);
        wr(4'd6, 32'd3);
        wr(4'd3, 32'd2);
        tb_pulses = 0;
        wr(4'd0, 32'h03);
        repeat (3) @(negedge clk);
        rd(4'd10, v); chk("R11 wide count", v, 32'h0001_0000);
        wait_ta(3, n);
        chk("R11 wide timeout", n, 1 + 32'h0001_0002 + 1);
        chk("R11 B held", tb_pulses, 0);
        rd(4'd0, v); chk("R11 one-shot stop", v[0], 0);
        wr(4'd1, 32'h00);

        // R9 / R12: PWM duty and polarity
        for (int i = 0; i < 3; i++) begin
            l = 4 + int'($urandom % 20);
            m = int'($urandom % l);
            wr(4'd1, 32'h08);
            wr(4'd2, 32'(l));
            wr(4'd4, 32'(m));
            wr(4'd6, 32'd0);
            wr(4'd8, 32'd0);
            wr(4'd0, 32'h01);
            repeat (3) @(negedge clk);
            count_high(l + 1, h);
            chk("R9 duty", h, exp_high(l, m));
            wr(4'd0, 32'h11);
            repeat (2) @(negedge clk);
            count_high(l + 1, h);
            chk("R9 inverted duty", h, (l + 1) - exp_high(l, m));
            wr(4'd1, 32'h04);
            #1;
            chk("R12 idle level inverted", pwm_a, 1);
            wr(4'd0, 32'h00);
            #1;
            chk("R12 idle level", pwm_a, 0);
        end

        // R10: 24-bit PWM compare
        wr(4'd1, 32'h08);
        wr(4'd2, 32'd5);
        wr(4'd6, 32'd1);
        wr(4'd4, 32'd2);
        wr(4'd8, 32'd1);
        wr(4'd0, 32'h01);
        for (int k = 1; k <= 7; k++) begin
            int c;
            @(negedge clk);
            c = 32'h10005 - (k - 1);
            chk("R10 24-bit compare", pwm_a, (c > 32'h10002) ? 1 : 0);
        end
        wr(4'd1, 32'h00);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule